// File: doc/BRIEF.md
# Reset Qualifier with Watchdog Reset Stretch

This block produces the chip-wide internal reset from two sources. The first is the external reset pin. It must be seen high for two full machine cycles of twelve oscillator periods each before it counts as a reset. The second is a free-running hardware watchdog. It times out unless software restarts it with a two-byte key written to a fixed register address.

When the watchdog times out, the block holds the internal reset for a fixed stretch of oscillator periods. During that stretch it asks the pad to drive the reset pin high, so that external devices reset along with the core. A disable input, taken from an auxiliary control register, suppresses the pin drive. The internal reset from a timeout still happens when the drive is disabled.

The reset-pin input is already synchronous to the oscillator clock. The write strobe, address and data come from the special-function register bus.

Top module: `rst_wdt_ctrl`

## Requirements
- R1: While `rst_ni` is low, `sys_rst_o` and `pin_drive_o` are both 0.
- R2: `sys_rst_o` goes high after 24 consecutive rising clock edges that sample `rst_pin_i` high. It is visible in the cycle after the 24th such edge, and 23 high samples are not enough.
- R3: A single edge that samples `rst_pin_i` low restarts the qualification count from zero. It also removes a pin-caused reset in the cycle after that edge.
- R4: Without a valid restart, the watchdog times out on the 16384th clock edge after the internal reset ends. The count starts at the first edge that samples `sys_rst_o` low. `sys_rst_o` is high in the cycle after the timeout edge.
- R5: A watchdog timeout holds `sys_rst_o` high for exactly 96 clock cycles.
- R6: With `drv_dis_i` = 0, `pin_drive_o` is high for exactly the same 96 cycles as the timeout reset, and is never high outside an internal reset.
- R7: With `drv_dis_i` = 1, `pin_drive_o` stays 0 while the 96-cycle internal reset from a timeout still occurs.
- R8: A write of 0x1E to address 0xA6, followed by a write of 0xE1 as the next write to 0xA6, zeroes the watchdog count. The next timeout then falls on the 16384th edge after the 0xE1 write edge. Writes to other addresses placed between the two keys do not break the sequence.
- R9: These writes do not restart the watchdog: 0xE1 to 0xA6 without a preceding 0x1E, a write to 0xA6 of any value other than 0xE1 after 0x1E (this cancels the pending key), and keys written to any address other than 0xA6.
- R10: While `sys_rst_o` is high, the watchdog count is held at zero and writes to 0xA6 are ignored, including any pending first key. No timeout can occur during an internal reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous power-on reset, active low |
| rst_pin_i | input | 1 | Synchronous sample of the external reset pin |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register write address |
| reg_wdata_i | input | 8 | Register write data |
| drv_dis_i | input | 1 | Disables the reset-pin drive on timeout |
| sys_rst_o | output | 1 | Internal reset, active high |
| pin_drive_o | output | 1 | Enable for driving the reset pin high |

## Verification
A wrong qualification count moves the rise of `sys_rst_o` by whole cycles, within 24 cycles of the pin going high. A wrong stretch count changes the width of the timeout reset or of `pin_drive_o`, which shows within 96 cycles. Faults in the watchdog counter or in the key-tracking state appear only at the next timeout, up to 16384 cycles later. For that reason the timeout edge is measured exactly after each key pattern, including patterns written during a reset that must be forgotten.

// File: rtl/rwd_pkg.sv
package rwd_pkg;
  typedef enum logic {
    KEY_IDLE  = 1'b0,
    KEY_ARMED = 1'b1
  } key_st_e;
endpackage

// File: rtl/rst_pin_qual.sv
module rst_pin_qual #(
  parameter int QUAL_LEN = 24
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic qual_o
);
  localparam int CW = $clog2(QUAL_LEN + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (!pin_i)                  cnt_q <= '0;
    else if (cnt_q != CW'(QUAL_LEN))  cnt_q <= cnt_q + 1'b1;
  end

  assign qual_o = (cnt_q == CW'(QUAL_LEN));
endmodule

// File: rtl/wdt_core.sv
module wdt_core
  import rwd_pkg::*;
#(
  parameter int                CNT_W     = 14,
  parameter int                ADDR_W    = 8,
  parameter int                DATA_W    = 8,
  parameter logic [ADDR_W-1:0] KICK_ADDR = 8'hA6,
  parameter logic [DATA_W-1:0] KEY_ARM   = 8'h1E,
  parameter logic [DATA_W-1:0] KEY_FIRE  = 8'hE1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hold_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              tmo_o
);
  logic [CNT_W-1:0] cnt_q;
  key_st_e          st_q;
  logic             hit, kick;

  assign hit   = we_i && (addr_i == KICK_ADDR) && !hold_i;
  assign kick  = hit && (st_q == KEY_ARMED) && (wdata_i == KEY_FIRE);
  // a restart on the last count wins over the timeout
  assign tmo_o = !hold_i && !kick && (&cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     st_q <= KEY_IDLE;
    else if (hold_i) st_q <= KEY_IDLE;
    else if (hit)    st_q <= (wdata_i == KEY_ARM) ? KEY_ARMED : KEY_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (hold_i || kick || tmo_o) cnt_q <= '0;
    else                             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/rst_stretch.sv
module rst_stretch #(
  parameter int LEN = 96
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic active_o
);
  localparam int CW = $clog2(LEN + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (start_i)     cnt_q <= CW'(LEN);
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign active_o = (cnt_q != '0);
endmodule

// File: rtl/rst_wdt_ctrl.sv
module rst_wdt_ctrl #(
  parameter int                OSC_PER_MC = 12,
  parameter int                QUAL_MC    = 2,
  parameter int                WDT_W      = 14,
  parameter int                DRIVE_CYC  = 96,
  parameter int                ADDR_W     = 8,
  parameter int                DATA_W     = 8,
  parameter logic [ADDR_W-1:0] KICK_ADDR  = 8'hA6,
  parameter logic [DATA_W-1:0] KEY_ARM    = 8'h1E,
  parameter logic [DATA_W-1:0] KEY_FIRE   = 8'hE1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rst_pin_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  input  logic              drv_dis_i,
  output logic              sys_rst_o,
  output logic              pin_drive_o
);
  localparam int QUAL_LEN = OSC_PER_MC * QUAL_MC;

  logic pin_rst, wdt_rst, wdt_tmo;

  rst_pin_qual #(.QUAL_LEN(QUAL_LEN)) u_qual (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (rst_pin_i),
    .qual_o (pin_rst)
  );

  wdt_core #(
    .CNT_W    (WDT_W),
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .KICK_ADDR(KICK_ADDR),
    .KEY_ARM  (KEY_ARM),
    .KEY_FIRE (KEY_FIRE)
  ) u_wdt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hold_i (sys_rst_o),
    .we_i   (reg_we_i),
    .addr_i (reg_addr_i),
    .wdata_i(reg_wdata_i),
    .tmo_o  (wdt_tmo)
  );

  rst_stretch #(.LEN(DRIVE_CYC)) u_str (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (wdt_tmo),
    .active_o(wdt_rst)
  );

  assign sys_rst_o   = pin_rst | wdt_rst;
  assign pin_drive_o = wdt_rst & ~drv_dis_i;
endmodule

// File: rtl/rst_wdt_ctrl_chk.sv
module rst_wdt_ctrl_chk #(
  parameter int WDT_W     = 14,
  parameter int DRIVE_CYC = 96
) (
  input logic clk_i,
  input logic rst_ni,
  input logic rst_pin_i,
  input logic drv_dis_i,
  input logic sys_rst_o,
  input logic pin_drive_o,
  input logic pin_rst,
  input logic wdt_rst,
  input logic wdt_tmo
);
  localparam int RW = $clog2(DRIVE_CYC + 2);
  localparam int SW = WDT_W + 1;

  logic [RW-1:0] run_len;
  logic [SW-1:0] since;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_len <= '0;
      since   <= '0;
    end else begin
      run_len <= wdt_rst ? run_len + 1'b1 : '0;
      if (sys_rst_o)  since <= '0;
      else if (!(&since)) since <= since + 1'b1;
    end
  end

  // R2
  qual_hist_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_rst |-> $past(rst_pin_i));
  // R3
  low_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(rst_pin_i) |-> !pin_rst);
  // R4
  tmo_not_early_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_tmo |-> since >= SW'((1 << WDT_W) - 1));
  // R5
  stretch_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wdt_rst) |-> run_len == RW'(DRIVE_CYC));
  // R6
  drive_in_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_drive_o |-> sys_rst_o);
  // R7
  drive_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drv_dis_i |-> !pin_drive_o);
  // R10
  no_tmo_in_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_o |-> !wdt_tmo);
  // R1
  always_comb begin
    if (!rst_ni) rst_quiet_chk: assert (!sys_rst_o && !pin_drive_o);
  end
endmodule

bind rst_wdt_ctrl rst_wdt_ctrl_chk #(.WDT_W(WDT_W), .DRIVE_CYC(DRIVE_CYC)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rst_pin_i  (rst_pin_i),
  .drv_dis_i  (drv_dis_i),
  .sys_rst_o  (sys_rst_o),
  .pin_drive_o(pin_drive_o),
  .pin_rst    (pin_rst),
  .wdt_rst    (wdt_rst),
  .wdt_tmo    (wdt_tmo)
);

// File: tb/test_rst_wdt_ctrl.sv
module test_rst_wdt_ctrl;
  localparam int TMO = 16384;
  localparam int STR = 96;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rst_pin = 1'b0;
  logic       we = 1'b0;
  logic [7:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       drv_dis = 1'b0;
  logic       sys_rst, pin_drive;

  int ecnt = 0;
  int base = 0;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;
  always @(posedge clk) ecnt <= ecnt + 1;

  rst_wdt_ctrl i_rst_wdt_ctrl (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .rst_pin_i  (rst_pin),
    .reg_we_i   (we),
    .reg_addr_i (addr),
    .reg_wdata_i(wdata),
    .drv_dis_i  (drv_dis),
    .sys_rst_o  (sys_rst),
    .pin_drive_o(pin_drive)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at edge %0d", req, act, exp, ecnt - base);
    end
  endtask

  task automatic wait_until(input int n);
    while (ecnt < base + n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0; rst_pin = 1'b0; we = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 sys_rst", sys_rst, 1'b0);
    chk("R1 pin_drive", pin_drive, 1'b0);
    rst_ni = 1'b1;
    base = ecnt;
  endtask

  task automatic t_pin_qual();
    do_reset();
    rst_pin = 1'b1;
    repeat (23) @(negedge clk);
    chk("R2 23 samples", sys_rst, 1'b0);
    @(negedge clk);
    chk("R2 24 samples", sys_rst, 1'b1);
    chk("R6 no drive on pin reset", pin_drive, 1'b0);
    rst_pin = 1'b0;
    @(negedge clk);
    chk("R3 release", sys_rst, 1'b0);
  endtask

  task automatic t_pin_glitch();
    do_reset();
    rst_pin = 1'b1;
    repeat (20) @(negedge clk);
    rst_pin = 1'b0;
    @(negedge clk);
    rst_pin = 1'b1;
    repeat (23) @(negedge clk);
    chk("R3 glitch restarts count", sys_rst, 1'b0);
    @(negedge clk);
    chk("R3 full count after glitch", sys_rst, 1'b1);
    rst_pin = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_timeout();
    int hi = 0;
    int dr = 0;
    drv_dis = 1'b0;
    do_reset();
    wait_until(TMO - 1);
    chk("R4 before timeout", sys_rst, 1'b0);
    wait_until(TMO);
    for (int i = 0; i < STR; i++) begin
      if (sys_rst) hi++;
      if (pin_drive) dr++;
      // R10: keys written during the stretch must be forgotten
      if (i == 10) wr(8'hA6, 8'h1E);
      else @(negedge clk);
    end
    chk("R5 96 reset cycles", hi == STR, 1'b1);
    chk("R6 96 drive cycles", dr == STR, 1'b1);
    chk("R5 reset ends", sys_rst, 1'b0);
    chk("R6 drive ends", pin_drive, 1'b0);
    wait_until(TMO + STR + 4);
    wr(8'hA6, 8'hE1);
    wait_until(TMO + STR + TMO - 1);
    chk("R10 count held during reset", sys_rst, 1'b0);
    wait_until(TMO + STR + TMO);
    chk("R10 second timeout on time", sys_rst, 1'b1);
    wait_until(TMO + STR + TMO + STR);
  endtask

  task automatic t_disable();
    int dr = 0;
    int hi = 0;
    drv_dis = 1'b1;
    do_reset();
    wait_until(TMO);
    for (int i = 0; i < STR; i++) begin
      if (sys_rst) hi++;
      if (pin_drive) dr++;
      @(negedge clk);
    end
    chk("R7 reset still 96", hi == STR, 1'b1);
    chk("R7 no drive", dr == 0, 1'b1);
    chk("R7 reset ends", sys_rst, 1'b0);
    drv_dis = 1'b0;
  endtask

  task automatic t_kick();
    int k;
    do_reset();
    wait_until(10000);
    wr(8'hA6, 8'h1E);
    wr(8'h8E, 8'h01);
    wr(8'hA6, 8'hE1);
    k = ecnt - base;
    wait_until(TMO);
    chk("R8 no timeout after restart", sys_rst, 1'b0);
    wait_until(k + TMO - 1);
    chk("R8 one before new timeout", sys_rst, 1'b0);
    wait_until(k + TMO);
    chk("R8 timeout after restart", sys_rst, 1'b1);
    wait_until(k + TMO + STR);
  endtask

  task automatic t_bad_keys();
    do_reset();
    wait_until(10000);
    wr(8'hA6, 8'hE1);
    wr(8'hA6, 8'h1E);
    wr(8'hA6, 8'h55);
    wr(8'hA6, 8'hE1);
    wr(8'hA5, 8'h1E);
    wr(8'hA6, 8'hE1);
    wait_until(TMO - 1);
    chk("R9 bad keys no restart", sys_rst, 1'b0);
    wait_until(TMO);
    chk("R9 timeout unchanged", sys_rst, 1'b1);
    wait_until(TMO + STR);
  endtask

  initial begin
    t_pin_qual();
    t_pin_glitch();
    t_timeout();
    t_disable();
    t_kick();
    t_bad_keys();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule